// File: doc/BRIEF.md
# Interrupt Line State Tracker

This block follows the state of a small set of physical interrupt inputs. Each input is configured as edge-triggered, level-triggered or message-type. For every line the block keeps a pending bit and an active bit, so each line is Inactive, Pending, Active or Pending+Active. It raises a request to the CPU while some enabled line is pending, that line is not active, and no interrupt is in service. A CPU acknowledge returns the lowest-numbered line that can be forwarded and marks that line active.

End of service can happen in one step or in two. With split mode off, an end-of-interrupt both drops the running priority and deactivates the named line. With split mode on, end-of-interrupt only drops the running priority, and the line stays active until a separate deactivate arrives. That deactivate can come from local software or from a linked virtual list register over a valid/ready channel. Software can also force a line active so that a level input that is still asserted is held back. On deactivation a level line takes a new sample of its input. An edge line becomes pending again only if an edge arrived while it was active. Message-type lines never become active.

Top module: `irq_state_tracker`

## Requirements
- R1: After reset every line is Inactive (`pend_o` and `act_o` all zero), `cpu_irq` is 0 and `running` is 0.
- R2: `cpu_irq` is 1 exactly when some line has `line_en`=1, pending=1 and active=0, and `running` is 0. A line that is Active or Pending+Active is never forwarded.
- R3: `ack_id` is the lowest-numbered line with `line_en`=1, pending=1 and active=0. `ack_none` is 1 when there is no such line or when `running` is 1. An `ack_req` while `ack_none`=0 makes that line Active with pending cleared (for an edge line, pending is kept set if a rising edge arrives in that same cycle) and sets `running`.
- R4: A `set_act_req` makes line `set_act_id` active without an acknowledge. A level line forced active and then held high is not forwarded.
- R5: A rising edge on an active edge line gives Pending+Active. After deactivation the line is pending, and so forwarded again, only if such an edge occurred.
- R6: A level line that is active does not gather pending from its input. On deactivation its pending bit takes the current input value. An inactive level line's pending bit follows its input.
- R7: `eoi` clears `running`. With `split_mode`=1 the line stays active. With `split_mode`=0 line `eoi_id` is also deactivated in the same cycle.
- R8: Message-type lines (`cfg_msg`=1, which overrides `cfg_level`) go pending on a rising edge, return to Inactive on acknowledge, never become active, and ignore set-active and deactivate.
- R9: Once `running` is set by an acknowledge, `cpu_irq` stays 0 until an `eoi`.
- R10: The linked deactivate channel transfers when `lr_valid` and `lr_ready` are both 1. A transfer deactivates line `lr_id` exactly as a local deactivate does. `lr_ready` is 0 in a cycle with `deact_req`=1, or with `eoi`=1 and `split_mode`=0, and 1 otherwise. The sender holds `lr_valid` and `lr_id` until the transfer.
- R11: A line with `line_en`=0 still tracks pending but is neither forwarded nor returned by acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N | Physical interrupt inputs |
| line_en | input | N | Per-line forward enable |
| cfg_level | input | N | 1 = level-triggered, 0 = edge-triggered |
| cfg_msg | input | N | 1 = message-type line (no active state) |
| split_mode | input | 1 | 1 = end-of-interrupt only drops priority |
| ack_req | input | 1 | CPU acknowledge pulse |
| ack_id | output | IDW | Line that an acknowledge would take |
| ack_none | output | 1 | No line can be acknowledged |
| eoi | input | 1 | End-of-interrupt pulse |
| eoi_id | input | IDW | Line named by end-of-interrupt |
| deact_req | input | 1 | Local deactivate pulse |
| deact_id | input | IDW | Line to deactivate locally |
| set_act_req | input | 1 | Software set-active pulse |
| set_act_id | input | IDW | Line to force active |
| lr_valid | input | 1 | Linked deactivate request valid |
| lr_ready | output | 1 | Linked deactivate request accepted |
| lr_id | input | IDW | Line named by the linked request |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| running | output | 1 | An acknowledged interrupt is in service |
| pend_o | output | N | Pending bit per line |
| act_o | output | N | Active bit per line |

## Verification
The bench puts a second edge on a line that is already active. A design that dropped this edge would lose the re-forward after deactivation, and one that kept pending alive without an edge would forward the line a second time. It deactivates a level line once with its input still high and once with the input low. This exposes a design that keeps a stale pending bit or never samples the input again. It sends a split-mode end-of-interrupt and then holds back a linked deactivate while a local deactivate happens in the same cycle. A design that cleared active early would forward too soon, and one that accepted both deactivates would take the linked request in the wrong cycle. Message lines are forced active and acknowledged to catch any active state left over. After the directed cases, random traffic is compared against a behavioural model on every cycle.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  typedef enum logic [1:0] {
    KIND_EDGE  = 2'd0,
    KIND_LEVEL = 2'd1,
    KIND_MSG   = 2'd2
  } line_kind_e;

  typedef struct packed {
    logic ack;
    logic deact;
    logic set_act;
  } line_cmd_t;
endpackage

// File: rtl/irq_trk_line.sv
module irq_trk_line
  import irq_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  line_kind_e kind,
  input  logic       irq,
  input  line_cmd_t  cmd,
  output logic       pend,
  output logic       act
);
  logic prev_q, pend_q, act_q;
  logic pend_n, act_n;
  logic rise;

  assign rise = irq & ~prev_q;

  always_comb begin
    pend_n = pend_q;
    act_n  = act_q;
    unique case (kind)
      KIND_MSG: begin
        act_n  = 1'b0;
        pend_n = cmd.ack ? rise : (pend_q | rise);
      end
      KIND_LEVEL: begin
        if (cmd.ack) begin
          pend_n = 1'b0;
          act_n  = 1'b1;
        end else if (cmd.deact) begin
          pend_n = irq;
          act_n  = 1'b0;
        end else begin
          pend_n = act_q ? (pend_q & irq) : irq;
          act_n  = act_q | cmd.set_act;
        end
      end
      default: begin
        if (cmd.ack) begin
          pend_n = rise;
          act_n  = 1'b1;
        end else if (cmd.deact) begin
          pend_n = pend_q | rise;
          act_n  = 1'b0;
        end else begin
          pend_n = pend_q | rise;
          act_n  = act_q | cmd.set_act;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      prev_q <= irq;
      pend_q <= pend_n;
      act_q  <= act_n;
    end
  end

  assign pend = pend_q;
  assign act  = act_q;
endmodule

// File: rtl/irq_trk_pick.sv
module irq_trk_pick #(
  parameter int N   = 8,
  localparam int IDW = $clog2(N)
) (
  input  logic [N-1:0]   cand,
  output logic [IDW-1:0] id,
  output logic           any
);
  always_comb begin
    id  = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        id  = IDW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_trk_deact.sv
module irq_trk_deact #(
  parameter int N   = 8,
  localparam int IDW = $clog2(N)
) (
  input  logic           deact_req,
  input  logic [IDW-1:0] deact_id,
  input  logic           eoi,
  input  logic [IDW-1:0] eoi_id,
  input  logic           split_mode,
  input  logic           lr_valid,
  input  logic [IDW-1:0] lr_id,
  output logic           lr_ready,
  output logic [N-1:0]   deact_mask
);
  logic eoi_deact;
  logic lr_take;

  assign eoi_deact = eoi & ~split_mode;
  assign lr_ready  = ~(deact_req | eoi_deact);
  assign lr_take   = lr_valid & lr_ready;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign deact_mask[g] = (deact_req & (deact_id == IDW'(g)))
                         | (eoi_deact & (eoi_id == IDW'(g)))
                         | (lr_take & (lr_id == IDW'(g)));
  end
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker
  import irq_trk_pkg::*;
#(
  parameter int N   = 8,
  localparam int IDW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   irq_in,
  input  logic [N-1:0]   line_en,
  input  logic [N-1:0]   cfg_level,
  input  logic [N-1:0]   cfg_msg,
  input  logic           split_mode,
  input  logic           ack_req,
  output logic [IDW-1:0] ack_id,
  output logic           ack_none,
  input  logic           eoi,
  input  logic [IDW-1:0] eoi_id,
  input  logic           deact_req,
  input  logic [IDW-1:0] deact_id,
  input  logic           set_act_req,
  input  logic [IDW-1:0] set_act_id,
  input  logic           lr_valid,
  output logic           lr_ready,
  input  logic [IDW-1:0] lr_id,
  output logic           cpu_irq,
  output logic           running,
  output logic [N-1:0]   pend_o,
  output logic [N-1:0]   act_o
);
  logic [N-1:0]   cand;
  logic [N-1:0]   deact_mask;
  logic [IDW-1:0] pick_id;
  logic           pick_any;
  logic           ack_hit;
  logic           run_q;

  assign cand = line_en & pend_o & ~act_o;

  irq_trk_pick #(.N(N)) u_pick (
    .cand (cand),
    .id   (pick_id),
    .any  (pick_any)
  );

  irq_trk_deact #(.N(N)) u_deact (
    .deact_req  (deact_req),
    .deact_id   (deact_id),
    .eoi        (eoi),
    .eoi_id     (eoi_id),
    .split_mode (split_mode),
    .lr_valid   (lr_valid),
    .lr_id      (lr_id),
    .lr_ready   (lr_ready),
    .deact_mask (deact_mask)
  );

  assign ack_hit = ack_req & pick_any & ~run_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    line_kind_e kind;
    line_cmd_t  cmd;
    assign kind = cfg_msg[g] ? KIND_MSG : (cfg_level[g] ? KIND_LEVEL : KIND_EDGE);
    assign cmd.ack     = ack_hit & (pick_id == IDW'(g));
    assign cmd.deact   = deact_mask[g];
    assign cmd.set_act = set_act_req & (set_act_id == IDW'(g));

    irq_trk_line u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .kind  (kind),
      .irq   (irq_in[g]),
      .cmd   (cmd),
      .pend  (pend_o[g]),
      .act   (act_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       run_q <= 1'b0;
    else if (ack_hit) run_q <= 1'b1;
    else if (eoi)     run_q <= 1'b0;
  end

  assign running  = run_q;
  assign cpu_irq  = pick_any & ~run_q;
  assign ack_id   = pick_id;
  assign ack_none = ~pick_any | run_q;
endmodule

// File: rtl/irq_trk_checker.sv
module irq_trk_checker #(
  parameter int N   = 8,
  localparam int IDW = $clog2(N)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cpu_irq,
  input logic           running,
  input logic           ack_req,
  input logic           ack_none,
  input logic [IDW-1:0] ack_id,
  input logic [N-1:0]   pend,
  input logic [N-1:0]   act,
  input logic [N-1:0]   line_en,
  input logic [N-1:0]   cfg_msg,
  input logic           deact_req,
  input logic           eoi,
  input logic           split_mode,
  input logic           lr_ready
);
  p_fwd_needs_cand_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (|(pend & ~act & line_en)));

  p_running_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !cpu_irq);

  p_ack_activates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_none && !cfg_msg[ack_id] && $stable(cfg_msg)) |=> act[$past(ack_id)]);

  p_ack_sets_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_none) |=> running);

  p_msg_no_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_none && cfg_msg[ack_id]) |=> !act[$past(ack_id)]);

  p_lr_backpressure_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (deact_req || (eoi && !split_mode)) |-> !lr_ready);
endmodule

bind irq_state_tracker irq_trk_checker #(.N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_irq    (cpu_irq),
  .running    (running),
  .ack_req    (ack_req),
  .ack_none   (ack_none),
  .ack_id     (ack_id),
  .pend       (pend_o),
  .act        (act_o),
  .line_en    (line_en),
  .cfg_msg    (cfg_msg),
  .deact_req  (deact_req),
  .eoi        (eoi),
  .split_mode (split_mode),
  .lr_ready   (lr_ready)
);

// File: tb/tb_irq_state_tracker.sv
`timescale 1ns/1ps
module tb_irq_state_tracker;
  localparam int N = 8;
  localparam int IDW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] irq_in, line_en, cfg_level, cfg_msg;
  logic split_mode, ack_req, eoi, deact_req, set_act_req, lr_valid;
  logic [IDW-1:0] eoi_id, deact_id, set_act_id, lr_id, ack_id;
  logic ack_none, lr_ready, cpu_irq, running;
  logic [N-1:0] pend_o, act_o;

  int n_checks = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  irq_state_tracker #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .line_en(line_en),
    .cfg_level(cfg_level), .cfg_msg(cfg_msg), .split_mode(split_mode),
    .ack_req(ack_req), .ack_id(ack_id), .ack_none(ack_none),
    .eoi(eoi), .eoi_id(eoi_id), .deact_req(deact_req), .deact_id(deact_id),
    .set_act_req(set_act_req), .set_act_id(set_act_id),
    .lr_valid(lr_valid), .lr_ready(lr_ready), .lr_id(lr_id),
    .cpu_irq(cpu_irq), .running(running), .pend_o(pend_o), .act_o(act_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] actual, input logic [31:0] expect_v);
    n_checks++;
    if (actual !== expect_v) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expect_v);
    end
  endtask

  // Behavioural reference model
  bit m_pend[N], m_act[N], m_prev[N];
  bit m_run;

  function automatic int m_pick();
    for (int i = 0; i < N; i++)
      if (line_en[i] && m_pend[i] && !m_act[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_pend[i] = 0; m_act[i] = 0; m_prev[i] = 0;
      end
      m_run = 0;
    end else begin
      int p;
      bit hit, lr_acc;
      p = m_pick();
      hit = ack_req && (p >= 0) && !m_run;
      lr_acc = lr_valid && !(deact_req || (eoi && !split_mode));
      for (int i = 0; i < N; i++) begin
        bit rise, a, d, s;
        rise = irq_in[i] && !m_prev[i];
        a = hit && (p == i);
        d = (deact_req && deact_id == i) || (eoi && !split_mode && eoi_id == i)
            || (lr_acc && lr_id == i);
        s = set_act_req && set_act_id == i;
        if (cfg_msg[i]) begin
          m_act[i] = 0;
          m_pend[i] = a ? rise : (m_pend[i] || rise);
        end else if (cfg_level[i]) begin
          if (a) begin m_pend[i] = 0; m_act[i] = 1; end
          else if (d) begin m_pend[i] = irq_in[i]; m_act[i] = 0; end
          else begin
            m_pend[i] = m_act[i] ? (m_pend[i] && irq_in[i]) : irq_in[i];
            m_act[i] = m_act[i] || s;
          end
        end else begin
          if (a) begin m_pend[i] = rise; m_act[i] = 1; end
          else if (d) begin m_pend[i] = m_pend[i] || rise; m_act[i] = 0; end
          else begin
            m_pend[i] = m_pend[i] || rise;
            m_act[i] = m_act[i] || s;
          end
        end
        m_prev[i] = irq_in[i];
      end
      if (hit) m_run = 1;
      else if (eoi) m_run = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [N-1:0] ep, ea;
      int p;
      for (int i = 0; i < N; i++) begin ep[i] = m_pend[i]; ea[i] = m_act[i]; end
      p = m_pick();
      chk("R5", "model pend", pend_o, ep);
      chk("R5", "model act", act_o, ea);
      chk("R9", "model running", running, m_run);
      chk("R2", "model cpu_irq", cpu_irq, (p >= 0) && !m_run);
      chk("R3", "model ack_none", ack_none, (p < 0) || m_run);
      if (p >= 0) chk("R3", "model ack_id", ack_id, p);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_ack();
    ack_req = 1; tick(); ack_req = 0;
  endtask

  task automatic do_eoi(input bit split, input int id);
    split_mode = split; eoi = 1; eoi_id = id[IDW-1:0]; tick(); eoi = 0;
  endtask

  task automatic do_deact(input int id);
    deact_req = 1; deact_id = id[IDW-1:0]; tick(); deact_req = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_n = 0; irq_in = '0; line_en = '1;
    cfg_level = 8'b0100_1100; cfg_msg = 8'b0011_0000;
    split_mode = 1; ack_req = 0; eoi = 0; eoi_id = '0;
    deact_req = 0; deact_id = '0; set_act_req = 0; set_act_id = '0;
    lr_valid = 0; lr_id = '0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1", "pend after reset", pend_o, 0);
    chk("R1", "act after reset", act_o, 0);
    chk("R1", "cpu_irq after reset", cpu_irq, 0);
    chk("R1", "running after reset", running, 0);

    // Edge lines 1 and 7
    irq_in[1] = 1; irq_in[7] = 1; tick();
    chk("R2", "cpu_irq with pending edge", cpu_irq, 1);
    chk("R3", "lowest id", ack_id, 1);
    do_ack();
    chk("R3", "line1 active", act_o[1], 1);
    chk("R3", "line1 pend cleared", pend_o[1], 0);
    chk("R9", "running masks line7", cpu_irq, 0);
    irq_in[1] = 0; tick(); irq_in[1] = 1; tick();
    chk("R5", "pending+active", {pend_o[1], act_o[1]}, 2'b11);
    do_eoi(1, 1);
    chk("R7", "split eoi keeps active", act_o[1], 1);
    chk("R7", "split eoi drops running", running, 0);
    chk("R2", "P+A line not chosen", ack_id, 7);
    do_deact(1);
    chk("R5", "re-forward after edge", {pend_o[1], act_o[1]}, 2'b10);
    chk("R5", "ack_id back to 1", ack_id, 1);
    do_ack();
    do_eoi(0, 1);
    chk("R7", "non-split eoi deactivates", {pend_o[1], act_o[1]}, 2'b00);
    chk("R7", "running clear", running, 0);
    do_ack();
    do_eoi(0, 7);
    chk("R5", "no edge, no re-forward", cpu_irq, 0);

    // Level line 2
    irq_in[2] = 1; tick();
    chk("R6", "level pending follows input", pend_o[2], 1);
    do_ack();
    tick();
    chk("R6", "active level gathers no pend", pend_o[2], 0);
    do_eoi(1, 2);
    chk("R2", "active line not forwarded", cpu_irq, 0);
    do_deact(2);
    chk("R6", "resample high", {pend_o[2], act_o[2]}, 2'b10);
    do_ack();
    irq_in[2] = 0;
    do_eoi(1, 2);
    do_deact(2);
    chk("R6", "resample low", {pend_o[2], act_o[2]}, 2'b00);

    // Set-active on level line 3
    set_act_req = 1; set_act_id = 3; tick(); set_act_req = 0;
    chk("R4", "forced active", act_o[3], 1);
    irq_in[3] = 1; tick(); tick();
    chk("R4", "held level masked", cpu_irq, 0);
    lr_valid = 1; lr_id = 3; #1;
    chk("R10", "lr_ready idle", lr_ready, 1);
    tick(); lr_valid = 0;
    chk("R10", "linked deactivate", {pend_o[3], act_o[3]}, 2'b10);
    chk("R10", "line3 forwarded", ack_id, 3);
    do_ack();
    do_eoi(1, 3);
    lr_valid = 1; lr_id = 3; deact_req = 1; deact_id = 5; #1;
    chk("R10", "lr_ready low on local deact", lr_ready, 0);
    tick(); deact_req = 0;
    chk("R10", "linked held back", act_o[3], 1);
    #1;
    chk("R10", "lr_ready back", lr_ready, 1);
    tick(); lr_valid = 0;
    chk("R10", "linked accepted", {pend_o[3], act_o[3]}, 2'b10);
    irq_in[3] = 0; tick();
    chk("R6", "inactive level follows low", pend_o[3], 0);

    // Message line 4
    irq_in[4] = 1; tick();
    chk("R8", "msg pending", pend_o[4], 1);
    chk("R8", "msg id", ack_id, 4);
    do_ack();
    chk("R8", "msg inactive after ack", {pend_o[4], act_o[4]}, 2'b00);
    do_eoi(1, 4);
    set_act_req = 1; set_act_id = 4; tick(); set_act_req = 0;
    chk("R8", "msg set-active ignored", act_o[4], 0);

    // Disabled line 5
    line_en[5] = 0; irq_in[5] = 1; tick();
    chk("R11", "disabled pend tracked", pend_o[5], 1);
    chk("R11", "disabled not forwarded", cpu_irq, 0);
    chk("R11", "disabled not acked", ack_none, 1);
    line_en[5] = 1; tick();
    chk("R11", "enabled forwarded", ack_id, 5);
    do_ack();
    do_eoi(1, 5);

    // Random traffic against the model
    for (int c = 0; c < 3000; c++) begin
      irq_in = 8'($urandom);
      if (c % 200 == 0) split_mode = $urandom_range(0, 1);
      if (c % 150 == 0) line_en = 8'($urandom) | 8'h81;
      ack_req = ($urandom_range(0, 3) == 0);
      eoi = ($urandom_range(0, 5) == 0); eoi_id = 3'($urandom);
      deact_req = ($urandom_range(0, 5) == 0); deact_id = 3'($urandom);
      set_act_req = ($urandom_range(0, 9) == 0); set_act_id = 3'($urandom);
      lr_valid = ($urandom_range(0, 4) == 0); lr_id = 3'($urandom);
      tick();
    end
    ack_req = 0; eoi = 0; deact_req = 0; set_act_req = 0; lr_valid = 0;
    tick();
    summary();
  end
endmodule